// File: doc/BRIEF.md
# Arithmetic Unit with Gated Status Flags

This block adds, subtracts or moves 32-bit values and keeps a four-bit status register holding negative (N), zero (Z), carry (C) and overflow (V). The arithmetic result appears on its output in the same cycle as its operands, whatever the other controls are doing. Each operation carries a set-flags bit, and the status register takes new values only when that bit and the enable are both high at a rising clock edge. An operation without the set-flags bit therefore leaves every earlier flag where it was.

A separate 4-bit condition code is tested against the stored flags and yields a pass bit. A sequencer can use it to decide whether a branch is taken or whether an instruction is executed. Because the test reads only the register and never the live result, a flag left by an older flag-setting operation still steers a later condition even after several non-flag-setting operations have run. Instruction decode and branching stay outside the block.

Top module: `flag_alu`

## Requirements
- R1: While the reset is held, and after it is released, the flags output reads 0000 until the first flag write.
- R2: The result is combinational from the inputs in every cycle, whatever en and set_flags are: op 00 gives a+b, op 01 gives a-b, both modulo 2^32, and op 10 or 11 (move) gives b.
- R3: The flags change only at a rising clock edge where en=1 and set_flags=1. In every other cycle they keep their value.
- R4: An add or subtract with a flag write stores N = result bit 31, Z = 1 when the result is zero, C = carry out (for subtract C=1 exactly when a >= b unsigned), and V = signed overflow. The flags port packs them as bit 3 N, bit 2 Z, bit 1 C, bit 0 V.
- R5: A move with a flag write sets N and Z from the moved value and keeps C and V. A nonzero value therefore clears Z.
- R6: cond_pass is combinational from the stored flags only, with codes 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always, and 1111 also always.
- R7: After a flag-setting move of a nonzero value, a subtract without set_flags whose result is zero leaves Z at 0, so code 0001 still passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Operation valid; qualifies flag writes |
| op | input | 2 | 00 add, 01 subtract, 1x move b |
| set_flags | input | 1 | Write the flags for this operation |
| a | input | 32 | First operand |
| b | input | 32 | Second operand or move value |
| cond | input | 4 | Condition code to test |
| result | output | 32 | Arithmetic result |
| flags | output | 4 | Stored N, Z, C, V (bits 3 to 0) |
| cond_pass | output | 1 | Condition evaluates true on the stored flags |

## Verification
The result is due in the cycle its operands are applied, so the bench checks it one nanosecond after it drives the inputs at a falling edge. Flags are due one rising edge after a qualifying operation, and the bench reads them one nanosecond after that edge. cond_pass follows the stored flags with no register, so every code sweep starts after the flag write has settled and checks each code at its own falling edge. After reset, the bench waits three edges for the internal release before it issues any operation.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MOVA = 2'b10,
    OP_MOVB = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic [3:0] {
    CC_EQ = 4'b0000, CC_NE = 4'b0001, CC_CS = 4'b0010, CC_CC = 4'b0011,
    CC_MI = 4'b0100, CC_PL = 4'b0101, CC_VS = 4'b0110, CC_VC = 4'b0111,
    CC_HI = 4'b1000, CC_LS = 4'b1001, CC_GE = 4'b1010, CC_LT = 4'b1011,
    CC_GT = 4'b1100, CC_LE = 4'b1101, CC_AL = 4'b1110, CC_NV = 4'b1111
  } cond_e;

endpackage

// File: rtl/flag_alu_rst_sync.sv
module flag_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= 1'b1;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= 1'b0;
        else        chain_q[gi] <= chain_q[gi-1];
      end
    end
  endgenerate

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/flag_alu_core.sv
module flag_alu_core
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] res,
  output nzcv_t        arith_f,
  output logic         is_move
);
  localparam int SW = W + 1;

  logic [W-1:0]  b_eff;
  logic          cin;
  logic [SW-1:0] sum;
  alu_op_e       op_e;

  always_comb begin
    op_e    = alu_op_e'(op);
    is_move = op[1];
    b_eff   = (op_e == OP_SUB) ? ~b : b;
    cin     = (op_e == OP_SUB);
    sum     = {1'b0, a} + {1'b0, b_eff} + {{(SW-1){1'b0}}, cin};
    res     = is_move ? b : sum[W-1:0];
    arith_f.n = res[W-1];
    arith_f.z = ~|res;
    arith_f.c = sum[SW-1];
    arith_f.v = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/flag_alu_flagreg.sv
module flag_alu_flagreg
  import flag_alu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  is_move,
  input  nzcv_t new_f,
  output nzcv_t cur_f
);
  nzcv_t flags_d, flags_q;

  always_comb begin
    flags_d = flags_q;
    if (wr_en) begin
      flags_d.n = new_f.n;
      flags_d.z = new_f.z;
      if (!is_move) begin
        flags_d.c = new_f.c;
        flags_d.v = new_f.v;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= '0;
    else if (wr_en) flags_q <= flags_d;
  end

  assign cur_f = flags_q;
endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
  import flag_alu_pkg::*;
(
  input  logic [3:0] cond,
  input  nzcv_t      f,
  output logic       pass
);
  logic ge;

  always_comb begin
    ge = (f.n == f.v);
    unique case (cond_e'(cond))
      CC_EQ: pass = f.z;
      CC_NE: pass = !f.z;
      CC_CS: pass = f.c;
      CC_CC: pass = !f.c;
      CC_MI: pass = f.n;
      CC_PL: pass = !f.n;
      CC_VS: pass = f.v;
      CC_VC: pass = !f.v;
      CC_HI: pass = f.c && !f.z;
      CC_LS: pass = !f.c || f.z;
      CC_GE: pass = ge;
      CC_LT: pass = !ge;
      CC_GT: pass = !f.z && ge;
      CC_LE: pass = f.z || !ge;
      default: pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   op,
  input  logic         set_flags,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   cond,
  output logic [W-1:0] result,
  output logic [3:0]   flags,
  output logic         cond_pass
);
  logic  rst_q_n;
  logic  is_move;
  logic  flag_wr;
  nzcv_t arith_f;
  nzcv_t cur_f;

  flag_alu_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  flag_alu_core #(.W(W)) u_core (
    .a(a), .b(b), .op(op), .res(result), .arith_f(arith_f), .is_move(is_move)
  );

  assign flag_wr = en && set_flags;

  flag_alu_flagreg u_flags (
    .clk(clk), .rst_n(rst_q_n), .wr_en(flag_wr), .is_move(is_move),
    .new_f(arith_f), .cur_f(cur_f)
  );

  flag_alu_cond u_cond (
    .cond(cond), .f(cur_f), .pass(cond_pass)
  );

  assign flags = cur_f;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         en,
  input logic [1:0]   op,
  input logic         set_flags,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   cond,
  input logic [W-1:0] result,
  input logic [3:0]   flags,
  input logic         cond_pass
);
  assert_add_result_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (op == 2'b00) |-> (result == W'(a + b)));

  assert_move_result_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    op[1] |-> (result == b));

  assert_hold_flags_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    !(en && set_flags) |=> $stable(flags));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (en && set_flags) |=> (flags[2] == ($past(result) == '0)));

  assert_neg_flag_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (en && set_flags) |=> (flags[3] == $past(result[W-1])));

  assert_sub_carry_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (en && set_flags && op == 2'b01) |=> (flags[1] == ($past(a) >= $past(b))));

  assert_move_keeps_cv_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (en && set_flags && op[1]) |=> (flags[1:0] == $past(flags[1:0])));

  assert_ne_pass_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (cond == 4'b0001) |-> (cond_pass == !flags[2]));

  assert_always_pass_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (cond[3:1] == 3'b111) |-> cond_pass);
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_ok(rst_q_n), .en(en), .op(op), .set_flags(set_flags),
  .a(a), .b(b), .cond(cond), .result(result), .flags(flags), .cond_pass(cond_pass)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
  logic        clk, rst_n, en, set_flags, cond_pass;
  logic [1:0]  op;
  logic [31:0] a, b, result;
  logic [3:0]  cond, flags;
  int checks, errors;
  logic [3:0] mf; // bench model of N,Z,C,V
  bit done;

  flag_alu u0 (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .set_flags(set_flags),
    .a(a), .b(b), .cond(cond), .result(result), .flags(flags), .cond_pass(cond_pass));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0: return z;           4'd1: return !z;
      4'd2: return cy;          4'd3: return !cy;
      4'd4: return n;           4'd5: return !n;
      4'd6: return v;           4'd7: return !v;
      4'd8: return cy & !z;     4'd9: return !cy | z;
      4'd10: return n == v;     4'd11: return n != v;
      4'd12: return !z & (n == v); 4'd13: return z | (n != v);
      default: return 1'b1;
    endcase
  endfunction

  // one operation: drive at falling edge, check result, then flags after the edge
  task automatic do_op(input logic e, input logic [1:0] o, input logic s,
                       input logic [31:0] x, input logic [31:0] y, input string req);
    logic [32:0] w;
    logic [31:0] r;
    logic [3:0]  nf;
    @(negedge clk);
    en = e; op = o; set_flags = s; a = x; b = y;
    nf = mf;
    if (o == 2'b00) begin
      w = {1'b0, x} + {1'b0, y}; r = w[31:0];
      nf = {r[31], r == 0, w[32], (x[31] == y[31]) && (r[31] != x[31])};
    end else if (o == 2'b01) begin
      r = x - y;
      nf = {r[31], r == 0, x >= y, (x[31] != y[31]) && (r[31] != x[31])};
    end else begin
      r = y;
      nf = {r[31], r == 0, mf[1:0]};
    end
    #1 chk({req, " result"}, result, r);
    @(posedge clk);
    #1;
    if (e && s) mf = nf;
    chk({req, " flags"}, {28'd0, flags}, {28'd0, mf});
    en = 1'b0; set_flags = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cond = 4'(c);
      #1 chk($sformatf("%s cond=%0d", req, c), {31'd0, cond_pass}, {31'd0, exp_pass(4'(c), mf)});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    mf = 4'b0000;
    chk("R1 flags in reset", {28'd0, flags}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1 flags after release", {28'd0, flags}, 32'd0);
  endtask

  task automatic t_plain();
    do_op(1, 2'b00, 0, 32'h1234_0000, 32'h0000_5678, "R2 R3 add no flags");
    do_op(1, 2'b01, 0, 32'd3, 32'd5, "R2 R3 sub no flags");
    do_op(1, 2'b10, 0, 32'd0, 32'd0, "R2 R3 move no flags");
  endtask

  task automatic t_arith();
    do_op(1, 2'b01, 1, 32'd5, 32'd5, "R4 sub equal");
    sweep("R6 after equal");
    do_op(1, 2'b01, 1, 32'd3, 32'd5, "R4 sub borrow");
    sweep("R6 after borrow");
    do_op(1, 2'b00, 1, 32'h7fff_ffff, 32'd1, "R4 add signed overflow");
    sweep("R6 after overflow");
    do_op(1, 2'b00, 1, 32'hffff_ffff, 32'd1, "R4 add carry zero");
    do_op(1, 2'b01, 1, 32'h8000_0000, 32'd1, "R4 sub signed overflow");
    sweep("R6 after sub overflow");
  endtask

  task automatic t_move();
    do_op(1, 2'b00, 1, 32'hffff_ffff, 32'd1, "R5 setup C Z");
    do_op(1, 2'b11, 1, 32'd0, 32'h8000_0000, "R5 move negative keeps C");
    do_op(1, 2'b10, 1, 32'd0, 32'd0, "R5 move zero sets Z");
  endtask

  task automatic t_gate();
    do_op(0, 2'b01, 1, 32'd7, 32'd7, "R3 en low blocks write");
    do_op(1, 2'b00, 0, 32'h7fff_ffff, 32'd1, "R3 set_flags low blocks write");
  endtask

  task automatic t_scenario();
    do_op(1, 2'b10, 1, 32'd0, 32'd1, "R7 move one");
    do_op(1, 2'b01, 0, 32'd1, 32'd1, "R7 sub without flags");
    @(negedge clk);
    cond = 4'b0001;
    #1 chk("R7 not-equal passes", {31'd0, cond_pass}, 32'd1);
    cond = 4'b0000;
    #1 chk("R7 equal fails", {31'd0, cond_pass}, 32'd0);
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0; mf = 4'b0000;
    rst_n = 1'b0; en = 0; set_flags = 0; op = 2'b00; a = '0; b = '0; cond = 4'b0000;
    do_reset();
    @(negedge clk);
    #1 chk("R6 EQ at reset", {31'd0, cond_pass}, 32'd0);
    t_plain();
    t_arith();
    t_move();
    t_gate();
    t_scenario();
    do_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule